// File: doc/BRIEF.md
# Infrared Serial Frame Receiver

This block sits behind a UART byte deserializer on a slow-rate infrared link. It turns the incoming byte stream into frames. It waits for a start flag and ignores any further start flags that come before the data. It undoes the escape coding of the sender and writes every recovered byte to a receive FIFO, including the two trailing check bytes. When the stop flag arrives, it posts a status word.

The block runs a CRC over the recovered bytes while they stream through, so no second pass is needed. It also counts them. At the end of each frame it raises three flags: an abort flag, a check-sum flag and a length flag. The flags are sticky and a host read strobe clears them. A start flag that lands inside a frame tells the FIFO to drop the partial frame, and reception then begins again.

Top module: `sir_frame_rx`

## Requirements
- R1: Before the first start flag (C0h) is seen, and after a frame ends, every received byte other than C0h is ignored: nothing is written to the FIFO and the status is left unchanged.
- R2: Start flags (C0h) received before the first data byte are all discarded, however many there are, and never written to the FIFO.
- R3: Inside a frame, a byte that is none of C0h, C1h or 7Dh is written unchanged to the FIFO. `fifo_wr_o` is high for one cycle after the clock edge that samples the byte. This includes the two check bytes.
- R4: An escape byte 7Dh is not written. The byte that follows it, if it is not C0h or C1h, is written with bit 5 inverted (XOR 20h).
- R5: A stop flag (C1h) inside a frame ends the frame and is not written. `stat_valid_o` rises two clock edges after the C1h is sampled.
- R6: The CRC is the reflected 16-bit CCITT form (polynomial 8408h, start value FFFFh, bits taken LSB first). It runs over every recovered byte. The sender sends the complement of the CRC over the payload, low byte first. A frame ended by C1h raises `stat_crc_err_o` unless the final residue is F0B8h.
- R7: A frame ended by C1h raises `stat_len_err_o` when its recovered byte count is below 4 or above `max_len_i`.
- R8: A 7Dh followed directly by C1h aborts the frame. It sets `stat_valid_o` and `stat_abort_o` and raises neither the CRC flag nor the length flag.
- R9: A start flag received after a data byte or after an escape byte pulses `fifo_drop_o` for one cycle. It posts no status, and the count and CRC restart for a new frame.
- R10: Status flags accumulate across frames until `status_rd_i` is sampled high, which clears them. A frame end sampled in the same cycle as the read leaves only that frame's flags set.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One received byte on rx_byte_i this cycle |
| rx_byte_i | input | 8 | Received byte |
| max_len_i | input | LEN_W | Largest recovered byte count that is accepted |
| status_rd_i | input | 1 | Host read strobe; clears the status flags |
| fifo_wr_o | output | 1 | Write strobe for the receive FIFO |
| fifo_data_o | output | 8 | Recovered byte |
| fifo_drop_o | output | 1 | Discard the bytes written since the last frame boundary |
| stat_valid_o | output | 1 | At least one frame has ended since the last read |
| stat_abort_o | output | 1 | Sticky abort flag |
| stat_crc_err_o | output | 1 | Sticky CRC error flag |
| stat_len_err_o | output | 1 | Sticky length error flag |

## Verification
The assertions assume that `rx_valid_i` carries one complete byte per valid cycle, and that `max_len_i` does not change while a frame is open. Under those conditions, event pulses never overlap, the counter and CRC reset after every restart, and the flags stay held until a read. The stimulus drives each byte for a single valid cycle followed by idle cycles, and it changes `max_len_i` only between frames. The sender in the bench escapes every C0h, C1h and 7Dh in the payload and check bytes, the same way a real transmitter would. Aborts, corrupted check bytes and mid-frame restarts are inserted on purpose.

// File: rtl/sir_rx_pkg.sv
package sir_rx_pkg;
  localparam logic [7:0]  FLAG_START = 8'hC0;
  localparam logic [7:0]  FLAG_STOP  = 8'hC1;
  localparam logic [7:0]  BYTE_ESC   = 8'h7D;
  localparam logic [7:0]  ESC_FLIP   = 8'h20;
  localparam logic [15:0] CRC_SEED   = 16'hFFFF;
  localparam logic [15:0] CRC_POLY   = 16'h8408;
  localparam logic [15:0] CRC_GOOD   = 16'hF0B8;

  typedef enum logic [1:0] {ST_HUNT, ST_HDR, ST_DATA, ST_ESC} rx_state_e;

  function automatic logic [15:0] crc_byte(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/sir_rx_fsm.sv
module sir_rx_fsm
  import sir_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_byte_i,
  output logic       data_vld_o,
  output logic [7:0] data_o,
  output logic       restart_o,
  output logic       drop_o,
  output logic       stop_o,
  output logic       abort_o
);
  rx_state_e  st_q;
  logic       data_vld_q, restart_q, drop_q, stop_q, abort_q;
  logic [7:0] data_q;
  logic       is_start, is_stop, is_esc;

  assign is_start = (rx_byte_i == FLAG_START);
  assign is_stop  = (rx_byte_i == FLAG_STOP);
  assign is_esc   = (rx_byte_i == BYTE_ESC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_HUNT;
      data_vld_q <= 1'b0;
      data_q     <= '0;
      restart_q  <= 1'b0;
      drop_q     <= 1'b0;
      stop_q     <= 1'b0;
      abort_q    <= 1'b0;
    end else begin
      data_vld_q <= 1'b0;
      restart_q  <= 1'b0;
      drop_q     <= 1'b0;
      stop_q     <= 1'b0;
      abort_q    <= 1'b0;
      if (rx_valid_i) begin
        unique case (st_q)
          ST_HUNT: begin
            if (is_start) begin
              restart_q <= 1'b1;
              st_q      <= ST_HDR;
            end
          end
          ST_HDR, ST_DATA: begin
            if (is_start) begin
              restart_q <= 1'b1;
              drop_q    <= (st_q == ST_DATA);
              st_q      <= ST_HDR;
            end else if (is_stop) begin
              stop_q <= 1'b1;
              st_q   <= ST_HUNT;
            end else if (is_esc) begin
              st_q <= ST_ESC;
            end else begin
              data_vld_q <= 1'b1;
              data_q     <= rx_byte_i;
              st_q       <= ST_DATA;
            end
          end
          ST_ESC: begin
            if (is_start) begin
              restart_q <= 1'b1;
              drop_q    <= 1'b1;
              st_q      <= ST_HDR;
            end else if (is_stop) begin
              abort_q <= 1'b1;
              st_q    <= ST_HUNT;
            end else begin
              data_vld_q <= 1'b1;
              data_q     <= rx_byte_i ^ ESC_FLIP;
              st_q       <= ST_DATA;
            end
          end
          default: st_q <= ST_HUNT;
        endcase
      end
    end
  end

  assign data_vld_o = data_vld_q;
  assign data_o     = data_q;
  assign restart_o  = restart_q;
  assign drop_o     = drop_q;
  assign stop_o     = stop_q;
  assign abort_o    = abort_q;

  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({data_vld_q, restart_q, stop_q, abort_q}));  // R5
  AST_DROP_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_q |-> restart_q);  // R9
  AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> !(data_vld_q || restart_q || stop_q || abort_q));  // R1
endmodule

// File: rtl/sir_rx_crc.sv
module sir_rx_crc
  import sir_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        upd_i,
  input  logic [7:0]  data_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= CRC_SEED;
    else if (clr_i)  crc_q <= CRC_SEED;
    else if (upd_i)  crc_q <= crc_byte(crc_q, data_i);
  end

  assign crc_o = crc_q;

  AST_CRC_RESEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (crc_q == CRC_SEED));  // R6
  AST_CRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !upd_i) |=> $stable(crc_q));  // R6
endmodule

// File: rtl/sir_rx_status.sv
module sir_rx_status
  import sir_rx_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int MIN_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_vld_i,
  input  logic             restart_i,
  input  logic             stop_i,
  input  logic             abort_i,
  input  logic [15:0]      crc_i,
  input  logic [LEN_W-1:0] max_len_i,
  input  logic             rd_i,
  output logic             valid_o,
  output logic             abort_o,
  output logic             crc_err_o,
  output logic             len_err_o
);
  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] CNT_MIN = LEN_W'(MIN_LEN);

  logic [LEN_W-1:0] cnt_q;
  logic [3:0]       flg_q, flg_new, flg_keep;
  logic             len_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cnt_q <= '0;
    else if (restart_i)                        cnt_q <= '0;
    else if (data_vld_i && cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
  end

  assign len_bad  = (cnt_q < CNT_MIN) || (cnt_q > max_len_i);
  // {valid, abort, crc, len}
  assign flg_new  = {stop_i | abort_i, abort_i, stop_i & (crc_i != CRC_GOOD), stop_i & len_bad};
  assign flg_keep = rd_i ? 4'b0 : flg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= flg_keep | flg_new;
  end

  assign valid_o   = flg_q[3];
  assign abort_o   = flg_q[2];
  assign crc_err_o = flg_q[1];
  assign len_err_o = flg_q[0];

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flg_q[3] && !rd_i) |=> flg_q[3]);  // R10
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !stop_i && !abort_i) |=> (flg_q == 4'b0));  // R10
  AST_ABORT_POSTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (flg_q[3] && flg_q[2]));  // R8
  AST_COUNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));  // R7
  AST_ERR_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flg_q[2] || flg_q[1] || flg_q[0]) |-> flg_q[3]);  // R5
endmodule

// File: rtl/sir_frame_rx.sv
module sir_frame_rx
  import sir_rx_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int MIN_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  input  logic [LEN_W-1:0] max_len_i,
  input  logic             status_rd_i,
  output logic             fifo_wr_o,
  output logic [7:0]       fifo_data_o,
  output logic             fifo_drop_o,
  output logic             stat_valid_o,
  output logic             stat_abort_o,
  output logic             stat_crc_err_o,
  output logic             stat_len_err_o
);
  logic        data_vld, restart, stop_ev, abort_ev;
  logic [7:0]  data;
  logic [15:0] crc;

  sir_rx_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_byte_i  (rx_byte_i),
    .data_vld_o (data_vld),
    .data_o     (data),
    .restart_o  (restart),
    .drop_o     (fifo_drop_o),
    .stop_o     (stop_ev),
    .abort_o    (abort_ev)
  );

  sir_rx_crc u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .upd_i  (data_vld),
    .data_i (data),
    .crc_o  (crc)
  );

  sir_rx_status #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_vld_i (data_vld),
    .restart_i  (restart),
    .stop_i     (stop_ev),
    .abort_i    (abort_ev),
    .crc_i      (crc),
    .max_len_i  (max_len_i),
    .rd_i       (status_rd_i),
    .valid_o    (stat_valid_o),
    .abort_o    (stat_abort_o),
    .crc_err_o  (stat_crc_err_o),
    .len_err_o  (stat_len_err_o)
  );

  assign fifo_wr_o   = data_vld;
  assign fifo_data_o = data;

  AST_WR_NOT_FLAG_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> !(stop_ev || abort_ev || fifo_drop_o));  // R3
endmodule

// File: tb/sim_sir_frame_rx.sv
module sim_sir_frame_rx;
  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             rx_valid;
  logic [7:0]       rx_byte;
  logic [LEN_W-1:0] max_len;
  logic             status_rd;
  logic             fifo_wr, fifo_drop;
  logic [7:0]       fifo_data;
  logic             s_valid, s_abort, s_crc, s_len;

  always #10 clk = ~clk;

  sir_frame_rx #(.LEN_W(LEN_W)) u0 (
    .clk_i (clk), .rst_ni (rst_n), .rx_valid_i (rx_valid), .rx_byte_i (rx_byte),
    .max_len_i (max_len), .status_rd_i (status_rd),
    .fifo_wr_o (fifo_wr), .fifo_data_o (fifo_data), .fifo_drop_o (fifo_drop),
    .stat_valid_o (s_valid), .stat_abort_o (s_abort),
    .stat_crc_err_o (s_crc), .stat_len_err_o (s_len)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // bench reference state
  int         mst;  // 0 hunt, 1 header, 2 data, 3 escape pending
  logic [15:0] mcrc;
  int         mcnt;
  logic [3:0] xflg;  // {valid, abort, crc, len}

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_step(input logic [15:0] c_in, input logic [7:0] d);
    logic [15:0] c;
    c = c_in;
    for (int i = 0; i < 8; i++) c = (c[0] ^ d[i]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit rd = 1'b0);
    bit         xw = 0, xd = 0;
    logic [7:0] xdat = 8'h00;
    logic [3:0] nflg = 4'b0;
    string      tag = "R1";
    case (mst)
      0: begin
        if (b == 8'hC0) begin mst = 1; mcrc = 16'hFFFF; mcnt = 0; tag = "R2"; end
      end
      1, 2: begin
        if (b == 8'hC0) begin
          xd = (mst == 2); tag = (mst == 2) ? "R9" : "R2";
          mst = 1; mcrc = 16'hFFFF; mcnt = 0;
        end else if (b == 8'hC1) begin
          nflg = {1'b1, 1'b0, mcrc != 16'hF0B8, (mcnt < 4) || (mcnt > int'(max_len))};
          tag = "R5 R6 R7"; mst = 0;
        end else if (b == 8'h7D) begin
          mst = 3; tag = "R4";
        end else begin
          xw = 1; xdat = b; mcrc = crc_step(mcrc, b); mcnt++; mst = 2; tag = "R3";
        end
      end
      default: begin
        if (b == 8'hC0) begin
          xd = 1; tag = "R9"; mst = 1; mcrc = 16'hFFFF; mcnt = 0;
        end else if (b == 8'hC1) begin
          nflg = 4'b1100; tag = "R8"; mst = 0;
        end else begin
          xw = 1; xdat = b ^ 8'h20; mcrc = crc_step(mcrc, xdat); mcnt++; mst = 2; tag = "R4";
        end
      end
    endcase
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0; status_rd = rd;
    chk(fifo_wr == xw, tag, "fifo_wr", fifo_wr, xw);
    if (xw) chk(fifo_data == xdat, tag, "fifo_data", fifo_data, xdat);
    chk(fifo_drop == xd, (tag == "R9") ? "R9" : tag, "fifo_drop", fifo_drop, xd);
    xflg = (rd ? 4'b0 : xflg) | nflg;
    @(negedge clk); status_rd = 1'b0;
    chk({s_valid, s_abort, s_crc, s_len} == xflg, rd ? "R10" : tag, "status",
        {s_valid, s_abort, s_crc, s_len}, xflg);
  endtask

  task automatic do_read();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    xflg = 4'b0;
    chk({s_valid, s_abort, s_crc, s_len} == 4'b0, "R10", "status after read",
        {s_valid, s_abort, s_crc, s_len}, 0);
  endtask

  task automatic send_stuffed(input logic [7:0] b);
    if (b == 8'hC0 || b == 8'hC1 || b == 8'h7D) begin
      send_byte(8'h7D); send_byte(b ^ 8'h20);
    end else send_byte(b);
  endtask

  // mode: 0 good, 1 corrupt check byte, 2 abort, 3 restart mid-frame
  task automatic send_frame(input int nstart, input logic [7:0] pl[$], input int mode, input bit rd_end = 0);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    foreach (pl[i]) c = crc_step(c, pl[i]);
    fcs = ~c;
    for (int i = 0; i < nstart; i++) send_byte(8'hC0);
    foreach (pl[i]) begin
      if (mode == 3 && i == pl.size() / 2) send_byte(8'hC0);
      send_stuffed(pl[i]);
    end
    send_stuffed(mode == 1 ? (fcs[7:0] ^ 8'h01) : fcs[7:0]);
    send_stuffed(fcs[15:8]);
    if (mode == 2) send_byte(8'h7D);
    send_byte(8'hC1, rd_end);
  endtask

  function automatic logic [7:0] pick_byte();
    case ($urandom_range(0, 7))
      0: return 8'hC0;
      1: return 8'hC1;
      2: return 8'h7D;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    logic [7:0] pl[$];
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00; status_rd = 1'b0; max_len = 8'd12;
    mst = 0; mcrc = 16'hFFFF; mcnt = 0; xflg = 4'b0;
    repeat (3) @(negedge clk);
    chk({fifo_wr, fifo_drop, s_valid, s_abort, s_crc, s_len} == 6'b0, "R11", "reset outputs",
        {fifo_wr, fifo_drop, s_valid, s_abort, s_crc, s_len}, 0);
    rst_n = 1'b1;

    // R1: noise before any start flag
    send_byte(8'h55); send_byte(8'hC1); send_byte(8'h7D); send_byte(8'h00);
    // R2 R3: several start flags then a good frame
    pl = '{8'h03, 8'h3F, 8'hAA, 8'h10};
    send_frame(4, pl, 0);
    do_read();
    // R4: every special value in the payload
    pl = '{8'hC0, 8'hC1, 8'h7D, 8'hE0};
    send_frame(2, pl, 0);
    // R1: bytes after frame end ignored, status held (R10)
    send_byte(8'h12); send_byte(8'h7D); send_byte(8'hC1);
    do_read();
    // R7: too short (only check bytes), empty frame, and over max
    pl = '{};
    send_frame(1, pl, 0);
    send_byte(8'hC0); send_byte(8'hC1);
    do_read();
    max_len = 8'd6;
    pl = '{8'h01, 8'h02, 8'h03, 8'h04};
    send_frame(1, pl, 0);
    do_read();
    pl = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
    send_frame(1, pl, 0);
    do_read();
    max_len = 8'd12;
    // R6: corrupted check byte
    pl = '{8'h21, 8'h22, 8'h23};
    send_frame(2, pl, 1);
    do_read();
    // R8: abort
    send_frame(2, pl, 2);
    do_read();
    // R9: restart mid-frame, also right after an escape
    pl = '{8'h31, 8'h32, 8'h33, 8'h34};
    send_frame(2, pl, 3);
    do_read();
    send_byte(8'hC0); send_byte(8'h41); send_byte(8'h7D); send_byte(8'hC0);
    send_byte(8'hC1);
    do_read();
    // R10: read in the same cycle as a frame end
    send_frame(1, pl, 1);
    send_frame(1, pl, 0, 1);
    do_read();

    for (int f = 0; f < 300; f++) begin
      int len = $urandom_range(0, 11);
      pl = '{};
      for (int i = 0; i < len; i++) pl.push_back(pick_byte());
      if ($urandom_range(0, 3) == 0) max_len = 8'($urandom_range(4, 14));
      if ($urandom_range(0, 5) == 0) send_byte(pick_byte());
      send_frame($urandom_range(1, 3), pl, ($urandom_range(0, 2) == 0) ? $urandom_range(1, 3) : 0,
                 $urandom_range(0, 7) == 0);
      if ($urandom_range(0, 2) != 0) do_read();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule